// File: doc/BRIEF.md
# Dual-Clock Line Delay Memory

This block is a word-wide line memory with two independent ports, each on its own clock. The write port stores one byte per enabled write-clock edge at the address held in its own counter, then advances that counter. The read port returns one word per enabled read-clock edge from the address held in a second, separate counter, then advances it. There are no full or empty flags and nothing is exchanged between the two clock domains. Each counter counts freely and wraps. The distance between the two counters is the delay the block gives, and the user sets it only by choosing when each port is cleared or paused.

Each port has an active-low enable and an active-low synchronous clear. Each port is also driven by a small state machine. The write side uses a two-state commit machine: `WS_IDLE` means no word is pending. `WS_PEND` means a word captured on the previous edge is written into the array on the current edge. Every edge moves this machine to `WS_PEND` when the write enable is low and to `WS_IDLE` when it is high. The read side uses an output machine: `RS_DRIVE` means the output buffer is on. `RS_HIZ` means the output is high impedance. Every edge moves this machine to `RS_DRIVE` when the read enable is low and to `RS_HIZ` when it is high. On each edge, both counters decode their enable and clear pair into one of three pointer operations: `OP_RST` forces the pointer to zero, `OP_ADV` steps it, and `OP_HOLD` keeps it.

The line length is 2^`ADDR_W` words. The default of 11 gives 2048 words, and `ADDR_W = 13` gives an 8192-word line of 8-bit data. Typical use is a one-line or n-word delay in an image or sample pipeline: the same stream is written and read back a fixed number of edges later.

Top module: `line_delay_mem`

## Requirements
- R1: A rising `wclk` edge with `wr_en_n` low and `wr_zero_n` high captures `wr_data` at the write pointer and increments the pointer. The storage holds 2^ADDR_W words of DATA_W bits.
- R2: A rising `wclk` edge with `wr_en_n` high writes nothing and leaves the write pointer unchanged, whatever `wr_data` carries.
- R3: A rising `wclk` edge with `wr_zero_n` low sets the write pointer to 0. If `wr_en_n` is also low on that edge, the byte is stored at address 0.
- R4: A rising `rclk` edge with `rd_en_n` low and `rd_zero_n` high loads `rd_data` with the word at the read pointer, sets `rd_oe` to 1 and increments the pointer.
- R5: A rising `rclk` edge with `rd_en_n` high leaves the read pointer unchanged. It also sets `rd_oe` to 0 and puts `rd_data` into high impedance from that edge on.
- R6: While `rd_zero_n` is low with `rd_en_n` low, every `rclk` edge returns the word at address 0 and the read pointer stays 0. The first edge after release reads address 0 again, and reading then continues from address 1.
- R7: If both pointers are cleared on the same edge and both enables then stay low, each word appears on `rd_data` exactly 2^ADDR_W edges after the edge that wrote it.
- R8: When the read clear is released n edges after the write clear, with 2 <= n <= 2^ADDR_W, the output lags the input by exactly n edges.
- R9: When both clears fall on the same edge and `rd_en_n` is then held high for n edges, with 2 <= n <= 2^ADDR_W, the output lags the input by exactly n edges. The output stays in high impedance during those n edges.
- R10: A captured word is written into the array on the next `wclk` edge. A read of that address on the same edge as the commit returns the earlier contents, so releasing the read clear 1 edge after the write clear gives a lag of 2^ADDR_W + 1.
- R11: Both pointers wrap from 2^ADDR_W - 1 to 0 with no flag or other indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-port clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_zero_n | input | 1 | Synchronous write-pointer clear, active low |
| wr_data | input | DATA_W | Byte to be stored |
| rclk | input | 1 | Read-port clock |
| rd_en_n | input | 1 | Read enable, active low |
| rd_zero_n | input | 1 | Synchronous read-pointer clear, active low |
| rd_data | output | DATA_W | Read word, high impedance while the port is disabled |
| rd_oe | output | 1 | High while `rd_data` is driven |

## Verification
The checker checks the per-edge pointer rules on every cycle: step on enable, hold on disable, zero on clear, and modular wrap. It also checks that a commit always follows a capture and that the output enable tracks the read enable with one register delay. The delays themselves can only be shown by the bench's scenarios, because they depend on where the two clears fall and on what the array holds: the one-line lag, the n-edge lag from a late read clear, the n-edge lag from a paused read port, and the extra edge of lag when a read meets an uncommitted word. The same applies to the repeated word 0 under a held read clear and to the bytes that are skipped during write gaps.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

    // Pointer operation decoded from a port's enable/clear pair each edge
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ADV  = 2'd1,
        OP_RST  = 2'd2
    } ptr_op_e;

    // Write commit machine
    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_PEND = 1'b1
    } wr_state_e;

    // Read output machine
    typedef enum logic {
        RS_HIZ   = 1'b0,
        RS_DRIVE = 1'b1
    } rd_state_e;

    // Clear wins over enable; enable low means step
    function automatic ptr_op_e decode_op(input logic en_n, input logic zero_n);
        if (!zero_n)    return OP_RST;
        else if (!en_n) return OP_ADV;
        else            return OP_HOLD;
    endfunction

endpackage

// File: rtl/ldm_wr_port.sv
module ldm_wr_port
    import ldm_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              en_n,
    input  logic              zero_n,
    input  logic [DATA_W-1:0] din,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [ADDR_W-1:0] ptr
);

    ptr_op_e           op;
    wr_state_e         state_q, state_d;
    logic [ADDR_W-1:0] acc_addr;

    always_comb begin
        op       = decode_op(en_n, zero_n);
        acc_addr = (op == OP_RST) ? '0 : ptr;
    end

    // Pointer register
    always_ff @(posedge clk) begin
        unique case (op)
            OP_RST:  ptr <= '0;
            OP_ADV:  ptr <= ptr + 1'b1;
            OP_HOLD: ptr <= ptr;
        endcase
    end

    // Commit machine: state register
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Commit machine: next state
    always_comb begin
        unique case (state_q)
            WS_IDLE: state_d = en_n ? WS_IDLE : WS_PEND;
            WS_PEND: state_d = en_n ? WS_IDLE : WS_PEND;
            default: state_d = WS_IDLE;
        endcase
    end

    // Capture stage feeding the array one edge later
    always_ff @(posedge clk) begin
        if (!en_n) begin
            mem_addr <= acc_addr;
            mem_data <= din;
        end
    end

    // Commit machine: outputs
    always_comb begin
        mem_we = (state_q == WS_PEND);
    end

endmodule

// File: rtl/ldm_rd_port.sv
module ldm_rd_port
    import ldm_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              en_n,
    input  logic              zero_n,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              drive,
    output logic [ADDR_W-1:0] ptr
);

    ptr_op_e   op;
    rd_state_e state_q, state_d;

    always_comb begin
        op       = decode_op(en_n, zero_n);
        mem_re   = !en_n;
        mem_addr = (op == OP_RST) ? '0 : ptr;
    end

    // Pointer register
    always_ff @(posedge clk) begin
        unique case (op)
            OP_RST:  ptr <= '0;
            OP_ADV:  ptr <= ptr + 1'b1;
            OP_HOLD: ptr <= ptr;
        endcase
    end

    // Output machine: state register
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Output machine: next state
    always_comb begin
        unique case (state_q)
            RS_HIZ:   state_d = en_n ? RS_HIZ : RS_DRIVE;
            RS_DRIVE: state_d = en_n ? RS_HIZ : RS_DRIVE;
            default:  state_d = RS_HIZ;
        endcase
    end

    // Output machine: outputs
    always_comb begin
        drive = (state_q == RS_DRIVE);
    end

endmodule

// File: rtl/ldm_array.sv
module ldm_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re) rdata <= store[raddr];
    end

endmodule

// File: rtl/line_delay_mem.sv
module line_delay_mem #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              wclk,
    input  logic              wr_en_n,
    input  logic              wr_zero_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rclk,
    input  logic              rd_en_n,
    input  logic              rd_zero_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [ADDR_W-1:0] wr_ptr;
    logic              mem_re;
    logic [ADDR_W-1:0] mem_raddr;
    logic [ADDR_W-1:0] rd_ptr;
    logic [DATA_W-1:0] q_word;

    ldm_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk      (wclk),
        .en_n     (wr_en_n),
        .zero_n   (wr_zero_n),
        .din      (wr_data),
        .mem_we   (mem_we),
        .mem_addr (mem_waddr),
        .mem_data (mem_wdata),
        .ptr      (wr_ptr)
    );

    ldm_rd_port #(.ADDR_W(ADDR_W)) u_rd (
        .clk      (rclk),
        .en_n     (rd_en_n),
        .zero_n   (rd_zero_n),
        .mem_re   (mem_re),
        .mem_addr (mem_raddr),
        .drive    (rd_oe),
        .ptr      (rd_ptr)
    );

    ldm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .rclk  (rclk),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (q_word)
    );

    assign rd_data = rd_oe ? q_word : {DATA_W{1'bz}};

endmodule

// File: rtl/ldm_checker.sv
module ldm_checker #(
    parameter int ADDR_W = 11
) (
    input logic              wclk,
    input logic              rclk,
    input logic              wr_en_n,
    input logic              wr_zero_n,
    input logic              rd_en_n,
    input logic              rd_zero_n,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic [ADDR_W-1:0] rd_ptr,
    input logic              mem_we,
    input logic              rd_oe
);

    // Each domain is armed once its own clear has been seen
    logic w_armed;
    logic r_armed;

    always_ff @(posedge wclk) begin
        if (!wr_zero_n) w_armed <= 1'b1;
    end

    always_ff @(posedge rclk) begin
        if (!rd_zero_n) r_armed <= 1'b1;
    end

    // R1 and R11: step by one, wrapping modulo the line length
    p_wr_step_r1: assert property (@(posedge wclk) disable iff (w_armed !== 1'b1)
        (wr_zero_n && !wr_en_n) |=> (wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1)));

    p_wr_hold_r2: assert property (@(posedge wclk) disable iff (w_armed !== 1'b1)
        (wr_zero_n && wr_en_n) |=> $stable(wr_ptr));

    p_wr_nocommit_r2: assert property (@(posedge wclk) disable iff (w_armed !== 1'b1)
        wr_en_n |=> !mem_we);

    p_wr_zero_r3: assert property (@(posedge wclk) disable iff (w_armed !== 1'b1)
        !wr_zero_n |=> (wr_ptr == '0));

    p_commit_next_r10: assert property (@(posedge wclk) disable iff (w_armed !== 1'b1)
        !wr_en_n |=> mem_we);

    // R4 and R11
    p_rd_step_r4: assert property (@(posedge rclk) disable iff (r_armed !== 1'b1)
        (rd_zero_n && !rd_en_n) |=> (rd_ptr == ADDR_W'($past(rd_ptr) + 1'b1)));

    p_rd_drive_r4: assert property (@(posedge rclk) disable iff (r_armed !== 1'b1)
        !rd_en_n |=> rd_oe);

    p_rd_hold_r5: assert property (@(posedge rclk) disable iff (r_armed !== 1'b1)
        (rd_zero_n && rd_en_n) |=> $stable(rd_ptr));

    p_rd_hiz_r5: assert property (@(posedge rclk) disable iff (r_armed !== 1'b1)
        rd_en_n |=> !rd_oe);

    p_rd_zero_r6: assert property (@(posedge rclk) disable iff (r_armed !== 1'b1)
        !rd_zero_n |=> (rd_ptr == '0));

endmodule

bind line_delay_mem ldm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .wclk      (wclk),
    .rclk      (rclk),
    .wr_en_n   (wr_en_n),
    .wr_zero_n (wr_zero_n),
    .rd_en_n   (rd_en_n),
    .rd_zero_n (rd_zero_n),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .mem_we    (mem_we),
    .rd_oe     (rd_oe)
);

// File: tb/line_delay_mem_tb.sv
module line_delay_mem_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 8;
    localparam int DEPTH      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              we_n = 1'b1;
    logic              wz_n = 1'b1;
    logic              re_n = 1'b1;
    logic              rz_n = 1'b1;
    logic [DATA_W-1:0] din  = '0;
    wire  [DATA_W-1:0] dout;
    wire               oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_delay_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .wclk      (clk),
        .wr_en_n   (we_n),
        .wr_zero_n (wz_n),
        .wr_data   (din),
        .rclk      (clk),
        .rd_en_n   (re_n),
        .rd_zero_n (rz_n),
        .rd_data   (dout),
        .rd_oe     (oe)
    );

    function automatic logic [DATA_W-1:0] pat(input int k, input int seed);
        return DATA_W'(k * 37 + seed * 11 + 5);
    endfunction

    // Inputs are set before the call; the result of the edge is visible after it
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_data(input string req, input logic [DATA_W-1:0] exp);
        checks++;
        if (oe !== 1'b1 || dout !== exp) begin
            errors++;
            $display("FAIL %s: oe=%b data=%h expected oe=1 data=%h", req, oe, dout, exp);
        end
    endtask

    task automatic chk_hiz(input string req);
        checks++;
        if (oe !== 1'b0) begin
            errors++;
            $display("FAIL %s: oe=%b expected oe=0", req, oe);
        end
    endtask

    // Read clear released n edges after write clear (n=0: same edge)
    task automatic run_clear_delay(input int n, input int seed);
        int lag;
        string tag;
        lag = (n == 0) ? DEPTH : (n == 1) ? DEPTH + 1 : n;
        tag = (n == 0) ? "R7 one-line lag" : (n == 1) ? "R10 uncommitted read" : "R8 clear delay";
        we_n = 1'b0; re_n = 1'b0; wz_n = 1'b0; rz_n = 1'b0; din = 8'h00;
        tick();
        wz_n = 1'b1;
        for (int j = 0; j < lag + 2 * DEPTH; j++) begin
            din  = pat(j, seed);
            rz_n = (j >= n);
            tick();
            if (j >= lag) chk_data(tag, pat(j - lag, seed));   // R11 wrap exercised beyond DEPTH
        end
    endtask

    // Both clears together, then the read port paused for n edges (R9)
    task automatic run_pause_delay(input int n, input int seed);
        we_n = 1'b0; re_n = 1'b0; wz_n = 1'b0; rz_n = 1'b0;
        tick();
        wz_n = 1'b1; rz_n = 1'b1;
        for (int j = 0; j < n + 2 * DEPTH; j++) begin
            din  = pat(j, seed);
            re_n = (j < n);
            tick();
            if (j < n) chk_hiz("R5 paused read");
            else       chk_data("R9 pause delay", pat(j - n, seed));
        end
    endtask

    // Write gaps, held read clear, mid-stream write clear
    task automatic run_gaps();
        int q;
        we_n = 1'b1; re_n = 1'b1; wz_n = 1'b0; rz_n = 1'b0;
        tick();
        wz_n = 1'b1; rz_n = 1'b1;
        q = 0;
        for (int e = 0; q < DEPTH - 2; e++) begin
            we_n = (e % 3 == 2);
            din  = we_n ? 8'hEE : pat(q, 7);
            tick();
            if (!we_n) q++;
        end
        we_n = 1'b1; din = 8'hEE;
        tick();
        re_n = 1'b0; rz_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk_data("R6 held read clear", pat(0, 7));
        end
        rz_n = 1'b1;
        for (int r = 0; r < DEPTH - 2; r++) begin
            tick();
            chk_data("R2 gap skip", pat(r, 7));
        end
        re_n = 1'b1;
        tick();
        chk_hiz("R5 disable");
        // R3: clear with enable stores at address 0
        we_n = 1'b0; wz_n = 1'b0; din = 8'hA5;
        tick();
        we_n = 1'b1; wz_n = 1'b1;
        tick();
        tick();
        re_n = 1'b0; rz_n = 1'b0;
        tick();
        chk_data("R3 clear write", 8'hA5);
        rz_n = 1'b1;
        tick();
        chk_data("R6 resume at 0", 8'hA5);
        tick();
        chk_data("R1 word 1 intact", pat(1, 7));
        re_n = 1'b1;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wz_n = 1'b0; rz_n = 1'b0;
        tick();
        tick();
        chk_hiz("R5 reset state");
        run_clear_delay(0, 1);
        run_clear_delay(1, 2);
        run_clear_delay(2, 3);
        run_clear_delay(5, 4);
        run_clear_delay(DEPTH - 1, 5);
        run_clear_delay(DEPTH, 6);
        run_pause_delay(2, 8);
        run_pause_delay(4, 9);
        run_pause_delay(DEPTH, 10);
        run_gaps();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule